// File: doc/BRIEF.md
# Subword Clock-Enabled Signed Register

This block stores a signed two's-complement word and skips loading the parts of it that carry no information. The word has a sign bit at the top and a magnitude field below it. The magnitude field is cut into equal slices, called subwords. A subword that is only a copy of the sign bit, with every slice above it also a copy of the sign bit, is not loaded. Its flip-flops keep their old contents, so a clock-enable or clock-gating flow can leave them idle.

Each subword decides whether to load from two things: the incoming sign bit and a single flag passed down from the slice directly above it. No wide comparison against stored data is needed. The sign bit loads on every cycle. One flag bit per subword records whether that slice was skipped. On read-out, a skipped slice is filled with copies of the stored sign bit, so the output always shows the full last input word. Typical users are datapath registers in filters and correlators, where small signals leave the upper slices unused.

Top module: `subword_gated_reg`

## Requirements
- R1: The word is SUBWORDS*SUB_BITS+1 bits wide. The sign is the most significant bit, and subword i occupies bits [i*SUB_BITS +: SUB_BITS], so subword 0 is the least significant slice.
- R2: The most significant subword has its load enable low exactly when all of its bits equal the incoming sign bit.
- R3: A lower subword has its load enable low only when all of its bits equal the sign bit and every subword above it also has its enable low. As a result, if a higher subword loads, every lower subword also loads.
- R4: load_en reflects the current din within the same cycle (it is combinational, with no register in the path), and load_en bit i = 1 means subword i loads at the next rising edge.
- R5: One rising edge after a word is applied with rst low, dout equals that word exactly. This holds whichever subwords were skipped.
- R6: When every load enable is 0, din is a pure sign extension (all bits equal to the sign), and on the next cycle dout is all copies of that sign bit.
- R7: Reset is synchronous and active high. At the first rising edge with rst high, dout becomes all zeros, and it stays all zeros until an edge with rst low loads new data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | SUBWORDS*SUB_BITS+1 | Signed input word |
| dout | output | SUBWORDS*SUB_BITS+1 | Reconstructed stored word |
| load_en | output | SUBWORDS | Per-subword load enable for the current din |

## Verification
The block has two timings. load_en is combinational: the bench checks it a short settle time after it changes din, within the same low phase of the clock. dout comes from a single register stage: the bench drives din on the falling edge and records the expected word in a queue. A monitor then takes the oldest entry a quarter period after the next rising edge and compares it with dout, so each comparison lands exactly one edge after its stimulus. Reset steps go into the same queue with an all-zero expectation. The same one-edge spacing therefore also covers the synchronous reset.

// File: rtl/subword_gated_reg.sv
module subword_gated_reg #(
  parameter int unsigned SUBWORDS = 4,
  parameter int unsigned SUB_BITS = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [SUBWORDS*SUB_BITS:0]     din,
  output logic [SUBWORDS*SUB_BITS:0]     dout,
  output logic [SUBWORDS-1:0]            load_en
);
  localparam int unsigned MAG = SUBWORDS * SUB_BITS;

  logic                sign_in;
  logic                sign_q;
  logic [SUBWORDS-1:0] noi;
  logic [SUBWORDS-1:0] flag_q;
  logic [MAG-1:0]      mag_q;

  assign sign_in   = din[MAG];
  assign load_en   = ~noi;
  assign dout[MAG] = sign_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_q <= 1'b0;
      flag_q <= '0;
    end else begin
      sign_q <= sign_in;
      flag_q <= noi;
    end
  end

  for (genvar g = 0; g < SUBWORDS; g++) begin : g_sub
    logic [SUB_BITS-1:0] slice;
    logic                upper_noi;
    assign slice = din[g*SUB_BITS +: SUB_BITS];

    if (g == SUBWORDS - 1) begin : g_top
      assign upper_noi = 1'b1;
    end else begin : g_low
      assign upper_noi = noi[g+1];

      p_cascade_r3: assert property (@(posedge clk) disable iff (rst)
        load_en[g+1] |-> load_en[g]);
    end

    assign noi[g] = upper_noi && (slice == {SUB_BITS{sign_in}});

    always_ff @(posedge clk) begin
      if (rst)
        mag_q[g*SUB_BITS +: SUB_BITS] <= '0;
      else if (!noi[g])
        mag_q[g*SUB_BITS +: SUB_BITS] <= slice;
    end

    assign dout[g*SUB_BITS +: SUB_BITS] =
      flag_q[g] ? {SUB_BITS{sign_q}} : mag_q[g*SUB_BITS +: SUB_BITS];
  end

  p_follow_r5: assert property (@(posedge clk) disable iff (rst)
    !rst |=> dout == $past(din));

  p_reset_r7: assert property (@(posedge clk)
    rst |=> dout == '0);

  p_skip_all_r6: assert property (@(posedge clk) disable iff (rst)
    (load_en == '0) |-> (din == {(MAG+1){din[MAG]}}));

  p_skip_out_r6: assert property (@(posedge clk) disable iff (rst)
    (load_en == '0) |=> (dout == {(MAG+1){$past(din[MAG])}}));

  p_top_r2: assert property (@(posedge clk) disable iff (rst)
    !load_en[SUBWORDS-1] |-> (din[MAG:MAG-SUB_BITS] == {(SUB_BITS+1){din[MAG]}}));
endmodule

// File: tb/subword_gated_reg_tb.sv
module subword_gated_reg_tb;
  localparam int unsigned SW = 4;
  localparam int unsigned SB = 4;
  localparam int unsigned W  = SW*SB + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  dout;
  logic [SW-1:0] load_en;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];
  bit           done = 1'b0;

  subword_gated_reg #(.SUBWORDS(SW), .SUB_BITS(SB)) u_dut (
    .clk(clk), .rst(rst), .din(din), .dout(dout), .load_en(load_en));

  always #10 clk = ~clk;

  function automatic logic [SW-1:0] model_en(input logic [W-1:0] d);
    logic [SW-1:0] e;
    for (int i = 0; i < SW; i++) begin
      e[i] = 1'b0;
      for (int b = i*SB; b < W-1; b++)
        if (d[b] != d[W-1]) e[i] = 1'b1;
    end
    return e;
  endfunction

  task automatic step(input logic r, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    rst = r;
    din = d;
    #2;
    checks++;
    if (load_en !== model_en(d)) begin
      errors++;
      $display("FAIL %s load_en act=%b exp=%b din=%h", tag, load_en, model_en(d), d);
    end
    exp_q.push_back(r ? '0 : d);
    tag_q.push_back(tag);
  endtask

  always begin
    @(posedge clk);
    #5;
    if (exp_q.size() > 0) begin
      logic [W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (dout !== e) begin
        errors++;
        $display("FAIL %s dout act=%h exp=%h", t, dout, e);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1'b1, 17'h00000, "R7 reset");
    step(1'b1, 17'h0ABCD, "R7 reset holds");
    step(1'b0, 17'h00000, "R6 zero");
    step(1'b0, 17'h1FFFF, "R6 minus one");
    step(1'b0, 17'h00005, "R1 small positive");
    step(1'b0, 17'h1FFFD, "R1 small negative");
    step(1'b0, 17'h00F00, "R3 sub2 info");
    step(1'b0, 17'h0F000, "R2 top info");
    step(1'b0, 17'h0F000, "R3 lower loads under top");
    step(1'b0, 17'h10000, "R5 most negative");
    step(1'b0, 17'h1FF00, "R3 negative sub1");
    step(1'b0, 17'h1FFFF, "R6 skip after full");
    step(1'b0, 17'h0F0F0, "R4 alternating");
    step(1'b0, 17'h00070, "R5 sub1 only");
    step(1'b0, 17'h0000F, "R5 sub0 only");
    step(1'b1, 17'h12345, "R7 mid reset");
    step(1'b0, 17'h1FFF8, "R5 after reset");
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] v;
      v = W'((k * 17'h0349B) ^ (k << 11));
      step(1'b0, v, "R5 sweep");
    end
    step(1'b0, 17'h00000, "R6 tail");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule